// File: doc/BRIEF.md
# Triggered Memory Streamer

This block moves a contiguous run of words out of a memory-mapped memory and plays them onto a parallel output port. The processor never touches the data. Software programs a start address, a word count and an addressing mode through a small register interface, then writes go. A pipelined bus master with a wait signal and a read-data-valid return starts prefetching words in the system clock domain. Those words cross into the domain of an externally supplied sample clock through an asynchronous FIFO.

Nothing reaches the output port until the external trigger input has been seen high. From then on, one word is presented per rising edge of the sample clock, with a strobe that marks each new word. If the memory cannot keep up and the FIFO runs dry, the port holds its last word and a sticky underrun flag is raised. When exactly the programmed number of words has left the port, the completion is handed back to the system domain. Software then sees busy drop and done rise.

Top module: `tms_stream_player`

## Requirements
- R1: After reset, the status register reads zero, `m_read` is low, `pin_data` is zero and `pin_strobe` is low.
- R2: Register offsets on `csr_addr` are: 0 start word address, 1 word count, 2 control (bit 0 go, bit 1 fixed-address mode), 3 status (bit 0 busy, bit 1 done, bit 2 underrun). Writing control with bit 0 set while idle starts a transfer: busy sets and done clears. Writes to offsets 0 to 2 are ignored while busy, or while the previous completion handshake is still draining.
- R3: With fixed-address mode clear, the master issues exactly `count` reads, at the start address and then at each following word address (modulo 2^ADDR_W).
- R4: With fixed-address mode set, every one of the `count` reads uses the start address.
- R5: The master keeps `m_read` and `m_addr` steady while `m_wait` is high. It never has more than MAX_OUT reads outstanding. It stops issuing reads while the FIFO free space is not larger than the outstanding count. Before any trigger, this means exactly FIFO_DEPTH reads are accepted.
- R6: No word appears on the output port before the trigger has been seen high. Afterwards, the words appear in read order, each marked by `pin_strobe` high for one sample-clock cycle, one per sample-clock edge while data is available.
- R7: While `pin_strobe` is low, `pin_data` keeps its last value. If the FIFO is empty during playout, status bit 2 (underrun) sets. It stays set until the next go is accepted.
- R8: After exactly `count` words have been strobed out, busy clears and done (status bit 1) sets. No further strobes follow.
- R9: A count of zero completes with done set, without any read and without any output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| csr_addr | input | 2 | Register offset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |
| m_addr | output | ADDR_W | Master word address |
| m_read | output | 1 | Master read request |
| m_wait | input | 1 | Slave stall; request must be held |
| m_rdata | input | DATA_W | Returned read data |
| m_rvalid | input | 1 | Returned data valid |
| sclk | input | 1 | External sample clock |
| trig | input | 1 | Asynchronous trigger level |
| pin_data | output | DATA_W | Output word, sample-clock domain |
| pin_strobe | output | 1 | New word on `pin_data` this sample cycle |

## Verification
The embedded assertions watch several rules on every clock:
- a stalled request stays stable;
- the outstanding count stays within its limit;
- address stepping and fixed addressing are correct;
- no FIFO write lands on a full FIFO and no read takes from an empty one;
- the output port holds its value between strobes;
- configuration stays stable while busy.

Some behaviour only the bench scenarios can show:
- trigger gating;
- the exact prefetch depth before a trigger;
- the order and values of the streamed words;
- the completion count;
- the zero-length case;
- underrun detection under a heavily stalled memory.

// File: rtl/tms_pkg.sv
package tms_pkg;

    localparam int unsigned DEF_ADDR_W = 20;
    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_LEN_W  = 16;
    localparam int unsigned CSR_W      = 32;

    // register offsets
    localparam logic [1:0] REG_BASE = 2'd0;
    localparam logic [1:0] REG_LEN  = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    localparam int unsigned CTRL_GO_BIT   = 0;
    localparam int unsigned CTRL_HOLD_BIT = 1;

    typedef struct packed {
        logic underrun;
        logic done;
        logic busy;
    } stat_t;

    typedef enum logic [1:0] {
        PL_IDLE,
        PL_ARMED,
        PL_RUN,
        PL_FIN
    } play_st_t;

    function automatic logic is_write_to(input logic wr, input logic [1:0] addr,
                                         input logic [1:0] target);
        return wr && (addr == target);
    endfunction

endpackage

// File: rtl/tms_bit_sync.sv
module tms_bit_sync #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [1:0] stage = {2{INIT}};

    always_ff @(posedge clk) begin
        if (rst) stage <= {2{INIT}};
        else     stage <= {stage[0], d};
    end

    assign q = stage[1];
endmodule

// File: rtl/tms_async_fifo.sv
module tms_async_fifo #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16
) (
    input  logic                      wclk,
    input  logic                      wrst,
    input  logic                      wr_en,
    input  logic [DATA_W-1:0]         wdata,
    output logic [$clog2(DEPTH):0]    free,
    output logic                      full,
    input  logic                      rclk,
    input  logic                      rrst,
    input  logic                      rd_en,
    output logic [DATA_W-1:0]         rdata,
    output logic                      empty
);
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned PTR_W = IDX_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];

    logic [PTR_W-1:0] wbin, wgray, rbin, rgray;
    logic [PTR_W-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
    logic [PTR_W-1:0] rbin_w, occ;
    logic [PTR_W-1:0] wbin_nx, rbin_nx;

    assign wbin_nx = wbin + PTR_W'(1);
    assign rbin_nx = rbin + PTR_W'(1);

    // gray to binary of the synchronized read pointer
    for (genvar g = 0; g < PTR_W; g++) begin : g_g2b
        assign rbin_w[g] = ^rg_s2[PTR_W-1:g];
    end

    assign occ   = wbin - rbin_w;
    assign full  = (occ == PTR_W'(DEPTH));
    assign free  = PTR_W'(DEPTH) - occ;
    assign empty = (rgray == wg_s2);
    assign rdata = mem[rbin[IDX_W-1:0]];

    // write domain
    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
            rg_s1 <= '0;
            rg_s2 <= '0;
        end else begin
            rg_s1 <= rgray;
            rg_s2 <= rg_s1;
            if (wr_en && !full) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_en && !full) mem[wbin[IDX_W-1:0]] <= wdata;
    end

    // read domain
    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
            wg_s1 <= '0;
            wg_s2 <= '0;
        end else begin
            wg_s1 <= wgray;
            wg_s2 <= wg_s1;
            if (rd_en && !empty) begin
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
            end
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (wrst)
        wr_en |-> !full) else $error("fifo write while full"); // R5

    AST_FIFO_NO_UNDERREAD: assert property (@(posedge rclk) disable iff (rrst)
        rd_en |-> !empty) else $error("fifo read while empty"); // R7
endmodule

// File: rtl/tms_read_engine.sv
module tms_read_engine #(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned MAX_OUT    = 4,
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             base,
    input  logic [LEN_W-1:0]              len,
    input  logic                          hold_addr,
    input  logic [$clog2(FIFO_DEPTH):0]   fifo_free,
    output logic [ADDR_W-1:0]             m_addr,
    output logic                          m_read,
    input  logic                          m_wait,
    input  logic                          m_rvalid
);
    localparam int unsigned OUT_W = $clog2(MAX_OUT + 1);

    logic [LEN_W-1:0] remain;
    logic [OUT_W-1:0] outst;
    logic             hold_q;
    logic             accept;
    logic             may_issue;

    assign accept    = m_read && !m_wait;
    assign may_issue = !m_read && (remain != '0)
                     && (outst < OUT_W'(MAX_OUT))
                     && (32'(fifo_free) > 32'(outst));

    always_ff @(posedge clk) begin
        if (rst) begin
            m_read <= 1'b0;
            m_addr <= '0;
            remain <= '0;
            outst  <= '0;
            hold_q <= 1'b0;
        end else begin
            if (start) begin
                m_addr <= base;
                remain <= len;
                hold_q <= hold_addr;
                m_read <= 1'b0;
            end else if (accept) begin
                m_read <= 1'b0;
                remain <= remain - LEN_W'(1);
                if (!hold_q) m_addr <= m_addr + ADDR_W'(1);
            end else if (may_issue) begin
                m_read <= 1'b1;
            end
            outst <= outst + OUT_W'(accept) - OUT_W'(m_rvalid);
        end
    end

    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        m_read && m_wait |=> m_read && $stable(m_addr)) else $error("request dropped under wait"); // R5

    AST_OUTST_LIMIT: assert property (@(posedge clk) disable iff (rst)
        outst <= OUT_W'(MAX_OUT)) else $error("too many reads outstanding"); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        accept && !hold_q |=> m_addr == $past(m_addr) + ADDR_W'(1)) else $error("address did not advance"); // R3

    AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (rst)
        accept && hold_q |=> $stable(m_addr)) else $error("fixed address moved"); // R4

    AST_NO_EXCESS_READ: assert property (@(posedge clk) disable iff (rst)
        m_read |-> remain != '0) else $error("read beyond count"); // R3
endmodule

// File: rtl/tms_playout.sv
module tms_playout
    import tms_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_lvl,
    input  logic              trig_raw,
    input  logic [LEN_W-1:0]  len,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic [DATA_W-1:0] pin_data,
    output logic              pin_strobe,
    output logic              fin,
    output logic              underrun
);
    play_st_t         st;
    logic [LEN_W-1:0] sent;
    logic             arm_d;
    logic             trig_s;
    logic             arm_rise;

    tms_bit_sync u_trig_sync (
        .clk (clk),
        .rst (rst),
        .d   (trig_raw),
        .q   (trig_s)
    );

    assign arm_rise = arm_lvl && !arm_d;
    assign fifo_rd  = !fifo_empty && (((st == PL_ARMED) && trig_s) || (st == PL_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= PL_IDLE;
            sent       <= '0;
            arm_d      <= 1'b0;
            pin_data   <= '0;
            pin_strobe <= 1'b0;
            fin        <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            arm_d      <= arm_lvl;
            pin_strobe <= 1'b0;
            unique case (st)
                PL_IDLE: begin
                    if (arm_rise) begin
                        sent     <= '0;
                        underrun <= 1'b0;
                        if (len == '0) begin
                            st  <= PL_FIN;
                            fin <= 1'b1;
                        end else begin
                            st <= PL_ARMED;
                        end
                    end
                end
                PL_ARMED, PL_RUN: begin
                    if (fifo_rd) begin
                        pin_data   <= fifo_data;
                        pin_strobe <= 1'b1;
                        sent       <= sent + LEN_W'(1);
                        if (sent + LEN_W'(1) == len) begin
                            st  <= PL_FIN;
                            fin <= 1'b1;
                        end else begin
                            st <= PL_RUN;
                        end
                    end else if (st == PL_RUN) begin
                        underrun <= 1'b1;
                    end
                end
                PL_FIN: begin
                    if (!arm_lvl) begin
                        st  <= PL_IDLE;
                        fin <= 1'b0;
                    end
                end
                default: st <= PL_IDLE;
            endcase
        end
    end

    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fifo_rd |=> $stable(pin_data) && !pin_strobe) else $error("output moved without a word"); // R7

    AST_SENT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st == PL_RUN) |-> (sent < len)) else $error("emitted past count"); // R8
endmodule

// File: rtl/tms_stream_player.sv
module tms_stream_player
    import tms_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned LEN_W      = DEF_LEN_W,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned MAX_OUT    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        csr_addr,
    input  logic              csr_wr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic [ADDR_W-1:0] m_addr,
    output logic              m_read,
    input  logic              m_wait,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_rvalid,
    input  logic              sclk,
    input  logic              trig,
    output logic [DATA_W-1:0] pin_data,
    output logic              pin_strobe
);
    localparam int unsigned FREE_W = $clog2(FIFO_DEPTH) + 1;

    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic              hold_q;
    logic              busy_q, done_q;
    logic              fin_s, fin_d, und_s;
    logic              go_acc, cfg_open, fin_rise;
    logic              srst, arm_s;
    logic              fin_raw, und_raw;
    logic              fifo_full, fifo_empty, fifo_rd;
    logic [FREE_W-1:0] fifo_free;
    logic [DATA_W-1:0] fifo_q;
    stat_t             stat;
    logic              unused_bits;

    assign unused_bits = ^{csr_wdata, fifo_full};

    // sample-domain reset, released two sample edges after rst falls
    tms_bit_sync #(.INIT(1'b1)) u_srst (
        .clk (sclk), .rst (1'b0), .d (rst), .q (srst)
    );
    tms_bit_sync u_arm_sync (
        .clk (sclk), .rst (srst), .d (busy_q), .q (arm_s)
    );
    tms_bit_sync u_fin_sync (
        .clk (clk), .rst (rst), .d (fin_raw), .q (fin_s)
    );
    tms_bit_sync u_und_sync (
        .clk (clk), .rst (rst), .d (und_raw), .q (und_s)
    );

    assign cfg_open = !busy_q && !fin_s;
    assign go_acc   = cfg_open && is_write_to(csr_wr, csr_addr, REG_CTRL)
                    && csr_wdata[CTRL_GO_BIT];
    assign fin_rise = fin_s && !fin_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            len_q  <= '0;
            hold_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            fin_d  <= 1'b0;
        end else begin
            fin_d <= fin_s;
            if (cfg_open && is_write_to(csr_wr, csr_addr, REG_BASE))
                base_q <= csr_wdata[ADDR_W-1:0];
            if (cfg_open && is_write_to(csr_wr, csr_addr, REG_LEN))
                len_q <= csr_wdata[LEN_W-1:0];
            if (cfg_open && is_write_to(csr_wr, csr_addr, REG_CTRL))
                hold_q <= csr_wdata[CTRL_HOLD_BIT];
            if (go_acc) begin
                busy_q <= 1'b1;
                done_q <= 1'b0;
            end else if (busy_q && fin_rise) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        stat.busy     = busy_q;
        stat.done     = done_q;
        stat.underrun = und_s;
        unique case (csr_addr)
            REG_BASE: csr_rdata = CSR_W'(base_q);
            REG_LEN:  csr_rdata = CSR_W'(len_q);
            REG_CTRL: csr_rdata = CSR_W'({hold_q, 1'b0});
            default:  csr_rdata = CSR_W'(stat);
        endcase
    end

    tms_read_engine #(
        .ADDR_W (ADDR_W), .LEN_W (LEN_W),
        .MAX_OUT (MAX_OUT), .FIFO_DEPTH (FIFO_DEPTH)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (go_acc),
        .base      (base_q),
        .len       (len_q),
        .hold_addr (csr_wdata[CTRL_HOLD_BIT]),
        .fifo_free (fifo_free),
        .m_addr    (m_addr),
        .m_read    (m_read),
        .m_wait    (m_wait),
        .m_rvalid  (m_rvalid)
    );

    tms_async_fifo #(.DATA_W (DATA_W), .DEPTH (FIFO_DEPTH)) u_fifo (
        .wclk  (clk),
        .wrst  (rst),
        .wr_en (m_rvalid),
        .wdata (m_rdata),
        .free  (fifo_free),
        .full  (fifo_full),
        .rclk  (sclk),
        .rrst  (srst),
        .rd_en (fifo_rd),
        .rdata (fifo_q),
        .empty (fifo_empty)
    );

    tms_playout #(.DATA_W (DATA_W), .LEN_W (LEN_W)) u_play (
        .clk        (sclk),
        .rst        (srst),
        .arm_lvl    (arm_s),
        .trig_raw   (trig),
        .len        (len_q),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_q),
        .fifo_rd    (fifo_rd),
        .pin_data   (pin_data),
        .pin_strobe (pin_strobe),
        .fin        (fin_raw),
        .underrun   (und_raw)
    );

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        busy_q && csr_wr |=> $stable(base_q) && $stable(len_q) && $stable(hold_q))
        else $error("config changed while busy"); // R2

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy_q && done_q)) else $error("busy and done together"); // R8

    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !m_read) else $error("read issued while idle"); // R9
endmodule

// File: tb/tms_stream_player_test.sv
module tms_stream_player_test;

    localparam int AW    = 20;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int LAT   = 3;
    localparam int LOGN  = 2048;

    typedef struct packed {
        logic [19:0] base;
        logic [15:0] len;
        logic        hold;
        logic [1:0]  stall;
        logic [7:0]  pre;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{base: 20'd100,    len: 16'd10, hold: 1'b0, stall: 2'd0, pre: 8'd5},
        '{base: 20'h00400,  len: 16'd37, hold: 1'b0, stall: 2'd1, pre: 8'd60},
        '{base: 20'h0002A,  len: 16'd12, hold: 1'b1, stall: 2'd0, pre: 8'd20},
        '{base: 20'hFFFFA,  len: 16'd9,  hold: 1'b0, stall: 2'd1, pre: 8'd10}
    };

    logic          clk = 0, sclk = 0, rst = 1;
    logic [1:0]    csr_addr = 0;
    logic          csr_wr = 0;
    logic [31:0]   csr_wdata = 0;
    logic [31:0]   csr_rdata;
    logic [AW-1:0] m_addr;
    logic          m_read, m_wait, m_rvalid;
    logic [DW-1:0] m_rdata;
    logic          trig = 0;
    logic [DW-1:0] pin_data;
    logic          pin_strobe;

    int checks = 0, failures = 0;
    logic [1:0] stall_mode = 0;
    logic [7:0] stall_cnt;
    logic [LAT-1:0] vpipe;
    logic [DW-1:0]  dpipe [LAT];

    logic [AW-1:0] acc_log [LOGN];
    logic [DW-1:0] cap_log [LOGN];
    int nacc = 0, ncap = 0, hold_viol = 0;
    logic [DW-1:0] last_word = 0;
    bit mon_en = 0;

    always #4  clk  = ~clk;
    always #20 sclk = ~sclk;

    tms_stream_player uut (
        .clk (clk), .rst (rst),
        .csr_addr (csr_addr), .csr_wr (csr_wr), .csr_wdata (csr_wdata), .csr_rdata (csr_rdata),
        .m_addr (m_addr), .m_read (m_read), .m_wait (m_wait), .m_rdata (m_rdata), .m_rvalid (m_rvalid),
        .sclk (sclk), .trig (trig), .pin_data (pin_data), .pin_strobe (pin_strobe)
    );

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return DW'((a * 37) ^ 20'h0A5C3);
    endfunction

    // memory slave model: fixed latency, selectable stall pattern
    assign m_wait = (stall_mode == 2'd1) ? (stall_cnt[1:0] == 2'd0)
                  : (stall_mode == 2'd2) ? (stall_cnt[3:0] != 4'd0) : 1'b0;
    assign m_rvalid = vpipe[LAT-1];
    assign m_rdata  = dpipe[LAT-1];

    always @(posedge clk) begin
        if (rst) begin
            vpipe     <= '0;
            stall_cnt <= '0;
        end else begin
            stall_cnt <= stall_cnt + 8'd1;
            vpipe     <= {vpipe[LAT-2:0], m_read && !m_wait};
            dpipe[0]  <= memf(m_addr);
            for (int i = 1; i < LAT; i++) dpipe[i] <= dpipe[i-1];
        end
    end

    always @(negedge clk) begin
        if (mon_en && m_read && !m_wait) begin
            acc_log[nacc % LOGN] = m_addr;
            nacc++;
        end
    end

    always @(negedge sclk) begin
        if (mon_en) begin
            if (pin_strobe) begin
                cap_log[ncap % LOGN] = pin_data;
                ncap++;
                last_word = pin_data;
            end else if (pin_data !== last_word) begin
                hold_viol++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_wr = 1;
        @(negedge clk);
        csr_wr = 0;
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int i = 0; i < 8000; i++) begin
            csr_read(2'd3, s);
            if (s[1]) begin ok = 1; break; end
        end
    endtask

    task automatic run_xfer(input logic [19:0] base, input logic [15:0] len, input bit hold,
                            input logic [1:0] stall, input int pre, input bit exp_und);
        int sa, sc, bad, fa, fe;
        bit ok;
        logic [31:0] s;
        logic [AW-1:0] ea;
        sa = nacc; sc = ncap;
        stall_mode = stall;
        csr_write(2'd0, 32'(base));
        csr_write(2'd1, 32'(len));
        csr_write(2'd2, {30'd0, hold, 1'b1});
        csr_read(2'd3, s);
        chk(s[0] == 1'b1 && s[1] == 1'b0, "R2", "busy set done clear after go", s[1:0], 1);
        repeat (pre) @(negedge clk);
        trig = 1;
        wait_done(ok);
        chk(ok, "R8", "done reached", ok, 1);
        repeat (60) @(negedge clk);
        trig = 0;
        chk(nacc - sa == int'(len), hold ? "R4" : "R3", "reads accepted", nacc - sa, len);
        bad = 0; fa = 0; fe = 0;
        for (int i = 0; i < int'(len) && i < nacc - sa; i++) begin
            ea = hold ? base : AW'(base + 20'(i));
            if (acc_log[(sa + i) % LOGN] !== ea) begin
                if (bad == 0) begin fa = int'(acc_log[(sa + i) % LOGN]); fe = int'(ea); end
                bad++;
            end
        end
        chk(bad == 0, hold ? "R4" : "R3", "read address sequence", fa, fe);
        chk(ncap - sc == int'(len), "R8", "words strobed out", ncap - sc, len);
        bad = 0; fa = 0; fe = 0;
        for (int i = 0; i < int'(len) && i < ncap - sc; i++) begin
            ea = hold ? base : AW'(base + 20'(i));
            if (cap_log[(sc + i) % LOGN] !== memf(ea)) begin
                if (bad == 0) begin fa = int'(cap_log[(sc + i) % LOGN]); fe = int'(memf(ea)); end
                bad++;
            end
        end
        chk(bad == 0, "R6", "output word order and values", fa, fe);
        csr_read(2'd3, s);
        chk(s[2:0] == {exp_und, 2'b10}, exp_und ? "R7" : "R8", "final status", s[2:0], {exp_und, 2'b10});
        chk(hold_viol == 0, "R7", "pin data held between strobes", hold_viol, 0);
    endtask

    task automatic run_all();
        logic [31:0] s;
        int sa, sc;
        bit ok;

        repeat (20) @(negedge clk);
        rst = 0;
        repeat (10) @(negedge clk);
        mon_en = 1;

        // R1: reset state
        csr_read(2'd3, s);
        chk(s == 32'd0, "R1", "status after reset", s, 0);
        chk(m_read == 1'b0 && pin_strobe == 1'b0, "R1", "no request or strobe after reset",
            {m_read, pin_strobe}, 0);
        chk(pin_data == '0, "R1", "pin data after reset", pin_data, 0);

        // table-driven transfers
        for (int v = 0; v < 4; v++) begin
            run_xfer(VECS[v].base, VECS[v].len, VECS[v].hold, VECS[v].stall,
                     int'(VECS[v].pre), 1'b0);
            repeat (40) @(negedge clk);
        end

        // R5 / R6 / R2: prefetch bound without trigger, ignored go while busy
        sa = nacc; sc = ncap;
        stall_mode = 0;
        csr_write(2'd0, 32'h300);
        csr_write(2'd1, 32'd40);
        csr_write(2'd2, 32'd1);
        repeat (150) @(negedge clk);
        chk(nacc - sa == DEPTH, "R5", "reads accepted before trigger", nacc - sa, DEPTH);
        chk(ncap - sc == 0, "R6", "no output before trigger", ncap - sc, 0);
        csr_write(2'd0, 32'h777);
        csr_write(2'd1, 32'd5);
        csr_write(2'd2, 32'd3);
        csr_read(2'd0, s);
        chk(s == 32'h300, "R2", "base write ignored while busy", s, 32'h300);
        csr_read(2'd1, s);
        chk(s == 32'd40, "R2", "count write ignored while busy", s, 40);
        csr_read(2'd2, s);
        chk(s[1] == 1'b0, "R2", "mode write ignored while busy", s[1], 0);
        trig = 1;
        wait_done(ok);
        chk(ok, "R8", "done after long run", ok, 1);
        repeat (60) @(negedge clk);
        trig = 0;
        chk(nacc - sa == 40, "R2", "second go did not restart reads", nacc - sa, 40);
        chk(acc_log[(sa + 39) % LOGN] == AW'(20'h300 + 39), "R3", "last read address",
            acc_log[(sa + 39) % LOGN], 20'h300 + 39);
        chk(ncap - sc == 40, "R8", "long run word count", ncap - sc, 40);
        chk(pin_data == memf(AW'(20'h300 + 39)), "R7", "pin holds final word after done",
            pin_data, memf(AW'(20'h300 + 39)));
        repeat (40) @(negedge clk);

        // R9: zero length
        sa = nacc; sc = ncap;
        csr_write(2'd1, 32'd0);
        csr_write(2'd2, 32'd1);
        trig = 1;
        wait_done(ok);
        chk(ok, "R9", "zero count completes", ok, 1);
        repeat (60) @(negedge clk);
        trig = 0;
        chk(nacc - sa == 0, "R9", "zero count issues no read", nacc - sa, 0);
        chk(ncap - sc == 0, "R9", "zero count emits no word", ncap - sc, 0);
        repeat (40) @(negedge clk);

        // R7: underrun under heavy stall, trigger immediately
        run_xfer(20'h01000, 16'd20, 1'b0, 2'd2, 0, 1'b1);
        repeat (40) @(negedge clk);

        // R7: sticky flag cleared by the next accepted go
        run_xfer(20'h02000, 16'd8, 1'b0, 2'd0, 30, 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                failures++;
                $display("FAIL WATCHDOG run hung actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule